// File: doc/BRIEF.md
# Oversampling Serial Receiver

This block is the receive half of an asynchronous serial adapter. It watches a serial input line, finds the start of each character, and shifts in 7 or 8 data bits least significant bit first. An optional parity bit and a stop bit follow the data. The input is sampled on every rising edge of the receive clock. At 16 or 64 clocks per bit the block places its own sample points. At one clock per bit the clock is assumed to be synchronized to the data outside the block.

Each finished character goes into a single holding register, together with its parity and framing result. A full flag then tells the host that a byte is waiting, and a one-cycle read strobe takes it. When a character finishes while the register is still full, that character is lost and an overrun is recorded. The overrun is reported to the host only after the byte still in the register has been read. A carrier-loss input keeps the deserializer idle and in its initial state.

Top module: `async_rx`

## Requirements
- R1: While `rst_n` is low, `rx_full`, `par_err`, `frm_err` and `ovr_err` are 0 and `rx_byte` is 0.
- R2: `rate_sel` 00 samples one bit per clock, 01 gives 16 clocks per bit, and 10 or 11 gives 64 clocks per bit. In the oversampled modes, a start is accepted on the 8th (or 32nd) consecutive low sample. In the one-clock mode it is accepted on the first low sample. Each later bit is sampled 16, 64 or 1 clocks after the previous sample. Data arrives least significant bit first.
- R3: In the oversampled modes, a low run shorter than half a bit returns the block to hunting for a start. No character results, and the next valid frame is received correctly.
- R4: `char7`=1 selects 7 data bits and `char7`=0 selects 8. When `par_en`=1, a parity bit follows the data, with `par_odd`=1 for odd parity and 0 for even. The data is delivered right-aligned, and in 7-bit formats bit 7 of `rx_byte` is 0.
- R5: `par_err` is 1 when the ones in the data plus the parity bit disagree with the selected parity. It is always 0 for a character received with `par_en`=0.
- R6: `frm_err` is 1 when the stop bit is sampled low. The character is still transferred.
- R7: A character is transferred only into an empty holding register. While the register stays full and no read occurs, `rx_byte`, `par_err` and `frm_err` keep their values.
- R8: A `rd_strobe` pulse clears `rx_full` on the next clock. If a character completes on the same clock as the read, that character is transferred, `rx_full` stays 1, and no overrun is recorded.
- R9: A character that completes while the register is full and unread is discarded and marks an overrun. `ovr_err` rises on the next read and is cleared by the read after that, or by reset. The characters that follow are received normally.
- R10: While `carrier_lost` is 1, the deserializer is held idle and no character is produced. The character already held in the register is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Master reset, active low |
| carrier_lost | input | 1 | High holds the deserializer idle |
| rxd | input | 1 | Serial data input, idle high |
| rate_sel | input | 2 | Clocks per bit: 00 one, 01 sixteen, 1x sixty-four |
| char7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 odd parity, 0 even |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| rx_byte | output | 8 | Held character |
| rx_full | output | 1 | Holding register contains an unread character |
| par_err | output | 1 | Parity mismatch of held character |
| frm_err | output | 1 | Stop bit of held character was low |
| ovr_err | output | 1 | At least one character was lost |

## Verification
The two functions that can fall on the same clock are the host read of the holding register and the completion of a new character at its stop-bit sample. The bench computes which clock carries the stop sample from the rate, the start-acceptance count and the frame length. It raises the read strobe on exactly that clock, with an older character still held. The result is correct when the new byte is in the register, the full flag has stayed set, and no overrun appears, either then or after the following read.

// File: rtl/async_rx.sv
module async_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       carrier_lost,
  input  logic       rxd,
  input  logic [1:0] rate_sel,
  input  logic       char7,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rd_strobe,
  output logic [7:0] rx_byte,
  output logic       rx_full,
  output logic       par_err,
  output logic       frm_err,
  output logic       ovr_err
);

  logic       busy;
  logic [5:0] phase;
  logic [4:0] lowcnt;
  logic [3:0] idx;
  logic [7:0] shreg;
  logic       pacc;
  logic       ovr_pend;

  wire [5:0] per_m1  = (rate_sel == 2'b00) ? 6'd0 : (rate_sel == 2'b01) ? 6'd15 : 6'd63;
  wire [4:0] half_m1 = (rate_sel == 2'b00) ? 5'd0 : (rate_sel == 2'b01) ? 5'd7  : 5'd31;
  wire [3:0] nbits    = char7 ? 4'd7 : 4'd8;
  wire [3:0] last_idx = nbits + {3'b000, par_en};

  wire sample = busy && (phase == per_m1);
  wire fin    = sample && (idx == last_idx);
  wire take   = fin && !carrier_lost && (!rx_full || rd_strobe);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= '0;
      lowcnt <= '0;
      idx    <= '0;
      shreg  <= '0;
      pacc   <= 1'b0;
    end else if (carrier_lost) begin
      busy   <= 1'b0;
      phase  <= '0;
      lowcnt <= '0;
      idx    <= '0;
    end else if (!busy) begin
      if (rxd) begin
        lowcnt <= '0;
      end else if (lowcnt == half_m1) begin
        busy   <= 1'b1;
        phase  <= '0;
        lowcnt <= '0;
        idx    <= '0;
        shreg  <= '0;
        pacc   <= 1'b0;
      end else begin
        lowcnt <= lowcnt + 5'd1;
      end
    end else if (sample) begin
      phase <= '0;
      idx   <= idx + 4'd1;
      if (idx < nbits) begin
        shreg[idx[2:0]] <= rxd;
        pacc            <= pacc ^ rxd;
      end else if (par_en && idx == nbits) begin
        pacc <= pacc ^ rxd;
      end
      if (fin) busy <= 1'b0;
    end else begin
      phase <= phase + 6'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte  <= '0;
      rx_full  <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      ovr_err  <= 1'b0;
      ovr_pend <= 1'b0;
    end else begin
      if (take) begin
        rx_byte <= shreg;
        par_err <= par_en && (pacc != par_odd);
        frm_err <= !rxd;
        rx_full <= 1'b1;
      end else if (rd_strobe) begin
        rx_full <= 1'b0;
      end
      if (rd_strobe) begin
        ovr_err  <= ovr_pend;
        ovr_pend <= 1'b0;
      end else if (fin && !carrier_lost && rx_full) begin
        ovr_pend <= 1'b1;
      end
    end
  end

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rd_strobe) |=> ($stable(rx_byte) && $stable(par_err) && $stable(frm_err)));

  a_r4_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_full) && $past(char7)) |-> !rx_byte[7]);

  a_r5_no_parity: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_full) && $past(!par_en)) |-> !par_err);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !fin) |=> !rx_full);

  a_r9_ovr_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(rd_strobe));

  a_r10_carrier_idle: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_lost |=> !busy);

endmodule

// File: tb/async_rx_tb.sv
`timescale 1ns/1ps
module async_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       carrier_lost = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] rate_sel = 2'b01;
  logic       char7 = 1'b0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_full, par_err, frm_err, ovr_err;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  async_rx dut_i (
    .clk(clk), .rst_n(rst_n), .carrier_lost(carrier_lost), .rxd(rxd),
    .rate_sel(rate_sel), .char7(char7), .par_en(par_en), .par_odd(par_odd),
    .rd_strobe(rd_strobe), .rx_byte(rx_byte), .rx_full(rx_full),
    .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd_pulse();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input bit flip_par, input bit bad_stop, input bit rd_at_stop);
    int bl, nb, np, nbit, half, stop_i, stop_pos, lowlen;
    logic [10:0] bits;
    logic [7:0] dm;
    logic p;
    bl = (rate_sel == 2'b00) ? 1 : (rate_sel == 2'b01) ? 16 : 64;
    nb = char7 ? 7 : 8;
    np = par_en ? 1 : 0;
    nbit = nb + np + 2;
    half = (bl == 1) ? 1 : bl / 2;
    lowlen = (bl == 1) ? 1 : bl / 2;
    dm = char7 ? (d & 8'h7F) : d;
    p = (^dm) ^ par_odd ^ flip_par;
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < nb; i++) bits[1+i] = dm[i];
    if (np == 1) bits[nb+1] = p;
    stop_i = nb + np + 1;
    bits[stop_i] = !bad_stop;
    stop_pos = half + bl * (nb + np + 1);
    for (int n = 1; n <= nbit * bl; n++) begin
      @(negedge clk);
      rxd = bits[(n-1)/bl];
      if (((n-1)/bl) == stop_i && bad_stop && ((n-1) % bl) >= lowlen) rxd = 1'b1;
      rd_strobe = rd_at_stop && (n == stop_pos);
    end
    @(negedge clk); rxd = 1'b1; rd_strobe = 1'b0;
    idle(4);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      done = 1;
      fails++; total++;
      $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, expd;
    idle(4);
    // R1 reset state
    chk(rx_full == 0 && par_err == 0 && frm_err == 0 && ovr_err == 0, "R1 flags", {rx_full, par_err, frm_err, ovr_err}, 0);
    chk(rx_byte == 0, "R1 byte", rx_byte, 0);
    rst_n = 1'b1;
    idle(4);

    // R2 R4 R5 R6 R8 sweep over rates, formats and data
    for (int r = 0; r < 3; r++) begin
      rate_sel = (r == 2) ? 2'b10 : r[1:0];
      for (int f = 0; f < 8; f++) begin
        char7 = f[0]; par_en = f[1]; par_odd = f[2];
        for (int k = 0; k < 4; k++) begin
          d = 8'hA5 ^ (8'h3C * k[7:0]) ^ (8'h11 * f[7:0]) ^ r[7:0];
          send(d, k == 2, k == 3, 1'b0);
          expd = char7 ? (d & 8'h7F) : d;
          chk(rx_byte == expd, "R2 R4 data", rx_byte, expd);
          chk(rx_full == 1, "R2 full", rx_full, 1);
          chk(par_err == (par_en && k == 2), "R5 parity", par_err, par_en && k == 2);
          chk(frm_err == (k == 3), "R6 framing", frm_err, k == 3);
          rd_pulse();
          chk(rx_full == 0, "R8 read clears", rx_full, 0);
        end
      end
    end

    // R3 false start rejection
    char7 = 0; par_en = 0; par_odd = 0;
    for (int r = 1; r < 3; r++) begin
      rate_sel = r[1:0];
      @(negedge clk); rxd = 1'b0;
      idle((r == 1) ? 6 : 30);
      @(negedge clk); rxd = 1'b1;
      idle(150);
      chk(rx_full == 0, "R3 no char", rx_full, 0);
      send(8'h5A, 0, 0, 0);
      chk(rx_byte == 8'h5A && rx_full, "R3 resync", rx_byte, 8'h5A);
      rd_pulse();
    end

    // R7 R9 overrun
    rate_sel = 2'b01;
    send(8'h11, 0, 1, 0);
    send(8'h22, 0, 0, 0);
    chk(rx_byte == 8'h11, "R7 held byte", rx_byte, 8'h11);
    chk(frm_err == 1, "R7 held flag", frm_err, 1);
    chk(ovr_err == 0, "R9 hidden", ovr_err, 0);
    rd_pulse();
    chk(ovr_err == 1 && rx_full == 0, "R9 visible", {ovr_err, rx_full}, 2);
    send(8'h33, 0, 0, 0);
    chk(rx_byte == 8'h33 && rx_full == 1, "R9 sync kept", rx_byte, 8'h33);
    chk(ovr_err == 1, "R9 sticky", ovr_err, 1);
    rd_pulse();
    chk(ovr_err == 0 && rx_full == 0, "R9 cleared", {ovr_err, rx_full}, 0);

    // R8 read on the stop-sample clock
    for (int r = 0; r < 3; r++) begin
      rate_sel = r[1:0];
      send(8'h44, 0, 0, 0);
      send(8'h55, 0, 0, 1);
      chk(rx_byte == 8'h55 && rx_full == 1, "R8 coincide", rx_byte, 8'h55);
      chk(ovr_err == 0, "R8 no overrun", ovr_err, 0);
      rd_pulse();
      chk(ovr_err == 0 && rx_full == 0, "R8 after read", {ovr_err, rx_full}, 0);
    end

    // R10 carrier loss
    rate_sel = 2'b01;
    send(8'h66, 0, 0, 0);
    carrier_lost = 1'b1;
    send(8'h00, 0, 0, 0);
    carrier_lost = 1'b0;
    chk(rx_byte == 8'h66 && rx_full == 1, "R10 held kept", rx_byte, 8'h66);
    chk(ovr_err == 0, "R10 no overrun", ovr_err, 0);
    rd_pulse();
    chk(rx_full == 0 && ovr_err == 0, "R10 nothing received", {rx_full, ovr_err}, 0);
    send(8'h77, 0, 0, 0);
    chk(rx_byte == 8'h77, "R10 resumes", rx_byte, 8'h77);
    rd_pulse();

    // R1 reset clears full and overrun
    send(8'h01, 0, 0, 0);
    send(8'h02, 0, 0, 0);
    rd_pulse();
    send(8'h03, 1, 1, 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(rx_full == 0 && ovr_err == 0 && frm_err == 0 && par_err == 0, "R1 reset clears", {rx_full, ovr_err, frm_err, par_err}, 0);
    chk(rx_byte == 0, "R1 reset byte", rx_byte, 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule